// File: doc/BRIEF.md
# Integer Multiply/Divide Unit

This block executes the 32-bit multiply, quotient and remainder operations of one processor instruction group. A 4-bit minor opcode, sampled together with a start strobe, selects the operation. The two source operands are sampled at the same time. The unit answers with a one-cycle done strobe. Alongside done it presents either a 32-bit result or one of two exception flags: divide-by-zero or illegal opcode.

Multiplies finish in the cycle after start and can be issued back to back. Quotient and remainder run on a radix-2 restoring engine that works on operand magnitudes. The sign is corrected in a final cycle. While that engine is occupied, further start strobes are ignored. The surrounding pipeline writes the result into its register file and raises any exception.

Top module: `muldiv_unit`

## Requirements
- R1: Minor opcode 8 returns bits 31:0 of the product of the two operands.
- R2: Minor opcode 10 returns bits 63:32 of the 64-bit product of the zero-extended operands.
- R3: Minor opcode 11 returns bits 63:32 of the 64-bit product of the sign-extended operands.
- R4: Minor opcode 12 returns the unsigned quotient and opcode 14 the unsigned remainder of operand A by operand B.
- R5: Minor opcode 13 returns the signed quotient, truncated toward zero. Opcode 15 returns the signed remainder, which carries the sign of operand A.
- R6: Operand A = 0x80000000 with operand B = 0xFFFFFFFF gives 0x80000000 for opcode 13 and 0 for opcode 15, with neither flag raised.
- R7: For opcodes 12 to 15 with operand B equal to zero, done and div_zero_o are high together in the cycle after start, and result_o keeps its previous value.
- R8: Opcodes 0 to 7 and 9 raise illegal_op_o together with done in the cycle after start, and result_o keeps its previous value.
- R9: done_o is high for exactly one cycle per accepted operation. That cycle is 1 cycle after the start cycle for multiplies and exceptions, and 34 cycles after it for quotient and remainder.
- R10: A start strobe seen while a quotient or remainder is in progress is ignored, up to and including the cycle before its done. It produces no done and does not change result_o.
- R11: After reset, result_o is 0 and done_o, div_zero_o and illegal_op_o are 0.
- R12: Multiplies started in consecutive cycles each produce their own done and result in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin an operation with the current opcode and operands |
| minor_op_i | input | 4 | Operation select |
| opnd_a_i | input | 32 | Multiplicand or dividend |
| opnd_b_i | input | 32 | Multiplier or divisor |
| result_o | output | 32 | Last produced result, held between operations |
| done_o | output | 1 | One-cycle completion strobe |
| div_zero_o | output | 1 | Divide by zero, valid with done_o |
| illegal_op_o | output | 1 | Reserved opcode, valid with done_o |

## Verification
The hardest case to reach is a start strobe that arrives in the sign-correction cycle of a divide. There the engine has finished iterating but has not yet reported. The stimulus counts cycles from a divide's start and injects multiply starts in cycle 5 and in cycle 33. The scoreboard then requires exactly one done, carrying the divide's result at cycle 34, and no later done. The most-negative by minus-one pair and the zero divisor also appear in the regular operand sweep, so each opcode meets them.

// File: rtl/muldiv_pkg.sv
`timescale 1ns/1ps
package muldiv_pkg;

  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_MUL_LO  = 4'd8,
    OP_MUL_HU  = 4'd10,
    OP_MUL_HS  = 4'd11,
    OP_QUO_U   = 4'd12,
    OP_QUO_S   = 4'd13,
    OP_REM_U   = 4'd14,
    OP_REM_S   = 4'd15
  } minor_op_e;

  typedef struct packed {
    logic illegal;
    logic is_mul;
    logic is_div;
    logic hi_word;
    logic sgn;
    logic want_rem;
  } op_ctl_t;

endpackage

// File: rtl/muldiv_rst_sync.sv
`timescale 1ns/1ps
module muldiv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/muldiv_decode.sv
`timescale 1ns/1ps
module muldiv_decode
  import muldiv_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output op_ctl_t         ctl_o
);
  always_comb begin
    ctl_o = '0;
    unique case (op_i)
      OP_MUL_LO: ctl_o.is_mul = 1'b1;
      OP_MUL_HU: begin ctl_o.is_mul = 1'b1; ctl_o.hi_word = 1'b1; end
      OP_MUL_HS: begin ctl_o.is_mul = 1'b1; ctl_o.hi_word = 1'b1; ctl_o.sgn = 1'b1; end
      OP_QUO_U:  ctl_o.is_div = 1'b1;
      OP_QUO_S:  begin ctl_o.is_div = 1'b1; ctl_o.sgn = 1'b1; end
      OP_REM_U:  begin ctl_o.is_div = 1'b1; ctl_o.want_rem = 1'b1; end
      OP_REM_S:  begin ctl_o.is_div = 1'b1; ctl_o.want_rem = 1'b1; ctl_o.sgn = 1'b1; end
      default:   ctl_o.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/muldiv_mult.sv
`timescale 1ns/1ps
module muldiv_mult #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         hi_i,
  input  logic         sgn_i,
  output logic [W-1:0] y_o
);
  localparam int unsigned PW = 2*W + 2;

  logic signed [PW-1:0] ext_a, ext_b, prod;

  always_comb begin
    ext_a = {{(PW-W){sgn_i & a_i[W-1]}}, a_i};
    ext_b = {{(PW-W){sgn_i & b_i[W-1]}}, b_i};
    prod  = ext_a * ext_b;
    y_o   = hi_i ? prod[2*W-1:W] : prod[W-1:0];
  end
endmodule

// File: rtl/muldiv_divider.sv
`timescale 1ns/1ps
module muldiv_divider #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         launch_i,
  input  logic         sgn_i,
  input  logic         rem_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic         busy_o,
  output logic         fin_o,
  output logic [W-1:0] res_o
);
  localparam int unsigned CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);
  localparam logic [W-1:0]  MOST_NEG = {1'b1, {(W-1){1'b0}}};

  typedef enum logic [1:0] {DV_IDLE, DV_RUN, DV_FIX} dv_state_e;

  dv_state_e      st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [W-1:0]   quo_q, quo_d;
  logic [W-1:0]   rem_q, rem_d;
  logic [W-1:0]   dvs_q, dvs_d;
  logic           negq_q, negq_d;
  logic           negr_q, negr_d;
  logic           rsel_q, rsel_d;
  logic           data_en;

  logic [W:0]     shifted;
  logic [W+1:0]   trial;
  logic [W-1:0]   mag;
  logic           neg_out;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    quo_d   = quo_q;
    rem_d   = rem_q;
    dvs_d   = dvs_q;
    negq_d  = negq_q;
    negr_d  = negr_q;
    rsel_d  = rsel_q;
    data_en = 1'b0;
    shifted = {rem_q, quo_q[W-1]};
    trial   = {1'b0, shifted} - {2'b00, dvs_q};
    unique case (st_q)
      DV_IDLE: begin
        if (launch_i) begin
          data_en = 1'b1;
          quo_d   = (sgn_i && dvd_i[W-1]) ? (~dvd_i + 1'b1) : dvd_i;
          dvs_d   = (sgn_i && dvs_i[W-1]) ? (~dvs_i + 1'b1) : dvs_i;
          rem_d   = '0;
          cnt_d   = '0;
          negq_d  = sgn_i & (dvd_i[W-1] ^ dvs_i[W-1]);
          negr_d  = sgn_i & dvd_i[W-1];
          rsel_d  = rem_i;
          st_d    = DV_RUN;
        end
      end
      DV_RUN: begin
        data_en = 1'b1;
        if (!trial[W+1]) begin
          rem_d = trial[W-1:0];
          quo_d = {quo_q[W-2:0], 1'b1};
        end else begin
          rem_d = shifted[W-1:0];
          quo_d = {quo_q[W-2:0], 1'b0};
        end
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST_STEP) st_d = DV_FIX;
      end
      default: st_d = DV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= DV_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      negq_q <= 1'b0;
      negr_q <= 1'b0;
      rsel_q <= 1'b0;
    end else if (data_en) begin
      cnt_q  <= cnt_d;
      quo_q  <= quo_d;
      rem_q  <= rem_d;
      dvs_q  <= dvs_d;
      negq_q <= negq_d;
      negr_q <= negr_d;
      rsel_q <= rsel_d;
    end
  end

  always_comb begin
    mag     = rsel_q ? rem_q : quo_q;
    neg_out = rsel_q ? negr_q : negq_q;
    res_o   = neg_out ? (~mag + 1'b1) : mag;
  end

  assign busy_o = (st_q != DV_IDLE);
  assign fin_o  = (st_q == DV_FIX);

  // R10
  launch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch_i |-> (st_q == DV_IDLE));

  // R9
  fin_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |=> !fin_o);

  // R9
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == DV_RUN) |-> (cnt_q <= LAST_STEP));

  // R6
  min_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_o && negr_q && !negq_q && dvs_q == W'(1) && quo_q == MOST_NEG)
      |-> (res_o == (rsel_q ? '0 : MOST_NEG)));
endmodule

// File: rtl/muldiv_unit.sv
`timescale 1ns/1ps
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [OP_W-1:0] minor_op_i,
  input  logic [W-1:0]    opnd_a_i,
  input  logic [W-1:0]    opnd_b_i,
  output logic [W-1:0]    result_o,
  output logic            done_o,
  output logic            div_zero_o,
  output logic            illegal_op_o
);
  logic         rst_n_s;
  op_ctl_t      ctl;
  logic [W-1:0] prod;
  logic [W-1:0] div_res;
  logic         div_busy, div_fin;
  logic         accept, zero_div, launch;

  logic [W-1:0] res_q, res_d;
  logic         res_en;
  logic         done_q, done_d;
  logic         dz_q, dz_d;
  logic         ill_q, ill_d;

  muldiv_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  muldiv_decode u_dec (.op_i(minor_op_i), .ctl_o(ctl));

  muldiv_mult #(.W(W)) u_mul (
    .a_i(opnd_a_i), .b_i(opnd_b_i), .hi_i(ctl.hi_word), .sgn_i(ctl.sgn), .y_o(prod)
  );

  assign accept   = start_i & ~div_busy;
  assign zero_div = ctl.is_div & (opnd_b_i == '0);
  assign launch   = accept & ctl.is_div & ~zero_div;

  muldiv_divider #(.W(W)) u_div (
    .clk(clk), .rst_n(rst_n_s), .launch_i(launch), .sgn_i(ctl.sgn),
    .rem_i(ctl.want_rem), .dvd_i(opnd_a_i), .dvs_i(opnd_b_i),
    .busy_o(div_busy), .fin_o(div_fin), .res_o(div_res)
  );

  always_comb begin
    res_d  = res_q;
    res_en = 1'b0;
    done_d = 1'b0;
    dz_d   = 1'b0;
    ill_d  = 1'b0;
    if (div_fin) begin
      res_d  = div_res;
      res_en = 1'b1;
      done_d = 1'b1;
    end else if (accept) begin
      if (ctl.illegal) begin
        done_d = 1'b1;
        ill_d  = 1'b1;
      end else if (zero_div) begin
        done_d = 1'b1;
        dz_d   = 1'b1;
      end else if (ctl.is_mul) begin
        res_d  = prod;
        res_en = 1'b1;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) res_q <= '0;
    else if (res_en) res_q <= res_d;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      done_q <= 1'b0;
      dz_q   <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      dz_q   <= dz_d;
      ill_q  <= ill_d;
    end
  end

  assign result_o     = res_q;
  assign done_o       = done_q;
  assign div_zero_o   = dz_q;
  assign illegal_op_o = ill_q;

  // R7
  dz_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    div_zero_o |-> done_o);

  // R8
  ill_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    illegal_op_o |-> (done_o && !div_zero_o));

  // R7 R8
  exc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (div_zero_o || illegal_op_o) |-> $stable(result_o));

  // R9 R12
  mul_lat_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (start_i && !div_busy && ctl.is_mul) |=> (done_o && !div_zero_o && !illegal_op_o));

  // R7
  dz_lat_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (start_i && !div_busy && zero_div) |=> div_zero_o);
endmodule

// File: tb/tb_muldiv_unit.sv
`timescale 1ns/1ps
module tb_muldiv_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MOST_NEG = 32'h8000_0000;
  localparam logic [31:0] ALL_ONES = 32'hFFFF_FFFF;

  logic        clk, rst_n, start;
  logic [3:0]  op;
  logic [31:0] a, b;
  logic [31:0] result_o;
  logic        done_o, div_zero_o, illegal_op_o;

  muldiv_unit dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .minor_op_i(op),
    .opnd_a_i(a), .opnd_b_i(b), .result_o(result_o), .done_o(done_o),
    .div_zero_o(div_zero_o), .illegal_op_o(illegal_op_o)
  );

  typedef struct {
    logic [31:0] res;
    logic        dz;
    logic        il;
    string       tag;
  } exp_t;

  exp_t        sbq[$];
  int          n_cmp = 0;
  int          n_bad = 0;
  logic [31:0] model_res = 32'h0;
  bit          ended = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [33:0] act, input logic [33:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  function automatic logic [31:0] ref_val(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
    logic [63:0]        ux, uy, up;
    logic signed [63:0] sx, sy, sp;
    ux = {32'b0, x};
    uy = {32'b0, y};
    sx = {{32{x[31]}}, x};
    sy = {{32{y[31]}}, y};
    case (o)
      4'd8:  begin up = ux * uy; return up[31:0];  end
      4'd10: begin up = ux * uy; return up[63:32]; end
      4'd11: begin sp = sx * sy; return sp[63:32]; end
      4'd12: return x / y;
      4'd14: return x % y;
      4'd13: begin
        if (x == MOST_NEG && y == ALL_ONES) return MOST_NEG;
        sp = sx / sy; return sp[31:0];
      end
      4'd15: begin
        if (x == MOST_NEG && y == ALL_ONES) return 32'h0;
        sp = sx % sy; return sp[31:0];
      end
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
    if (o < 4'd8 || o == 4'd9) return "R8";
    if (o >= 4'd12 && y == 0) return "R7";
    if ((o == 4'd13 || o == 4'd15) && x == MOST_NEG && y == ALL_ONES) return "R6";
    case (o)
      4'd8:  return "R1";
      4'd10: return "R2";
      4'd11: return "R3";
      4'd12, 4'd14: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic bit is_div_op(input logic [3:0] o);
    return o >= 4'd12;
  endfunction

  task automatic push(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
    exp_t e;
    e.tag = tag_of(o, x, y);
    e.dz  = 1'b0;
    e.il  = 1'b0;
    if (o < 4'd8 || o == 4'd9) begin
      e.il = 1'b1; e.res = model_res;
    end else if (is_div_op(o) && y == 0) begin
      e.dz = 1'b1; e.res = model_res;
    end else begin
      e.res = ref_val(o, x, y);
      model_res = e.res;
    end
    sbq.push_back(e);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R10", "unexpected done", {div_zero_o, illegal_op_o, result_o}, 34'h0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check({div_zero_o, illegal_op_o, result_o} == {e.dz, e.il, e.res}, e.tag,
              "flags/result", {div_zero_o, illegal_op_o, result_o}, {e.dz, e.il, e.res});
      end
    end
  end

  // issue one operation and wait for its done; R9 latency check
  task automatic issue(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
    int lat;
    int exp_lat;
    @(negedge clk);
    start = 1'b1; op = o; a = x; b = y;
    push(o, x, y);
    exp_lat = (is_div_op(o) && y != 0) ? 34 : 1;
    lat = 1;
    @(negedge clk);
    start = 1'b0;
    while (!done_o && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    check(lat == exp_lat, "R9", "latency", 34'(lat), 34'(exp_lat));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] vals [8];
    logic [3:0]  ops  [7];
    vals = '{32'h0, 32'h1, ALL_ONES, MOST_NEG, 32'h7FFF_FFFF, 32'h7, 32'hFFFF_FFF9, 32'h1234_5678};
    ops  = '{4'd8, 4'd10, 4'd11, 4'd12, 4'd13, 4'd14, 4'd15};
    start = 1'b0; op = 4'd0; a = '0; b = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R11 during reset
    check(result_o == 0 && !done_o && !div_zero_o && !illegal_op_o, "R11", "in reset",
          {div_zero_o, illegal_op_o, result_o}, 34'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 after release
    check(result_o == 0 && !done_o && !div_zero_o && !illegal_op_o, "R11", "after reset",
          {div_zero_o, illegal_op_o, result_o}, 34'h0);

    // sweep: R1 R2 R3 R4 R5 R6 R7
    foreach (ops[i]) begin
      foreach (vals[j]) begin
        for (int k = 0; k < 8; k++) issue(ops[i], vals[j], vals[k]);
      end
      for (int r = 0; r < 30; r++) issue(ops[i], $urandom, $urandom);
    end

    // R6 explicit
    issue(4'd13, MOST_NEG, ALL_ONES);
    issue(4'd15, MOST_NEG, ALL_ONES);

    // R8 reserved opcodes after a known result
    issue(4'd8, 32'd6, 32'd7);
    for (int o = 0; o < 10; o++) begin
      if (o != 8) issue(4'(o), 32'h55, 32'h3);
    end
    // R7 zero divisor on every divide opcode
    for (int o = 12; o < 16; o++) issue(4'(o), 32'hDEAD_BEEF, 32'h0);

    // R12 back-to-back multiplies
    @(negedge clk);
    start = 1'b1; op = 4'd8;  a = 32'd3;        b = 32'd9;        push(op, a, b);
    @(negedge clk);
    op = 4'd11; a = ALL_ONES;   b = 32'd5;  push(op, a, b);
    @(negedge clk);
    op = 4'd10; a = ALL_ONES;   b = ALL_ONES;   push(op, a, b);
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    check(sbq.size() == 0, "R12", "pending after burst", 34'(sbq.size()), 34'h0);

    // R10 starts during divide, including sign-fix cycle
    begin
      int lat;
      @(negedge clk);
      start = 1'b1; op = 4'd13; a = 32'hFFFF_FF9C; b = 32'd7;
      push(op, a, b);
      lat = 1;
      @(negedge clk);
      start = 1'b0;
      while (!done_o && lat < 60) begin
        if (lat == 5 || lat == 33) begin
          start = 1'b1; op = 4'd8; a = 32'd3; b = 32'd5;
        end else begin
          start = 1'b0;
        end
        @(negedge clk);
        lat++;
      end
      start = 1'b0;
      check(lat == 34, "R10", "divide latency with stray starts", 34'(lat), 34'd34);
      repeat (5) @(negedge clk);
      check(sbq.size() == 0 && result_o == 32'hFFFF_FFF2, "R10", "stray start effect",
            {2'b0, result_o}, {2'b0, 32'hFFFF_FFF2});
    end

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule